// File: doc/BRIEF.md
# Far-Address Extension Unit

This unit sits beside an 8-bit accumulator CPU whose memory address is 16 bits wide and widens it so that a 512K SRAM can be reached as one linear space. It watches the SRAM strobes. A cycle in which output-enable and write-enable are both low is a control-store cycle. In such a cycle it reads the control code from the low address byte, the Y register from the upper address byte, and the accumulator from the ALU lines. The unit only decodes codes whose two low bits are not both zero. Ordinary codes pass to the existing bank logic through a strobe.

The unit holds a 3-bit high-address register `z` and a one-shot prefix flag. Some new codes load `z` from one of four sources: an immediate, the accumulator, Y, or the current video bank. Other codes arm the prefix, and some do both. While the prefix is armed, the next instruction's SRAM access drives `z` onto address lines 18:16 in place of the bank select. If that instruction's addressing mode has no Y component, the middle address byte is also forced to zero. The prefix is gone after that instruction whatever it did.

Top module: `far_ext_unit`

## Requirements
- R1: A control-store cycle is one with `sram_oe_ni` and `sram_we_ni` both low. `ctrl_strobe_o` is high only in such a cycle and only when `code_i[1:0]` is 00. `z_o` changes only at the end of such a cycle or on reset.
- R2: Code low nibble 2 loads `z_o` from `code_i[6:4]` without arming the prefix. Low nibble 3 loads the same value and arms the prefix.
- R3: Code 0x51 loads `z_o` from `alu_i[2:0]`. Code 0xD1 does the same and arms the prefix.
- R4: Code 0x61 loads `z_o` from `addr_mid_i[2:0]`, the Y byte of the Y-addressed control store. Code 0xE1 does the same and arms the prefix.
- R5: Code 0x71 loads `z_o` from `vbank_odd_i` when `alu_i[7]` is 1 and from `vbank_even_i` when it is 0. Code 0xF1 does the same and arms the prefix.
- R6: Code 0x41 changes nothing. Code 0xC1 arms the prefix and leaves `z_o` unchanged. Any other code with low nibble 1 (0x01–0x31, 0x81–0xB1) and any code with low bits 01/10/11 outside the above changes neither `z_o` nor the prefix.
- R7: `prefix_o` is high for exactly the one cycle after the arming control store. A non-memory instruction also consumes it. A control store that arms again keeps it high.
- R8: `sram_addr_hi_o` equals `z_o` when the prefix is armed and the current access is extendable (see R10). Otherwise it equals `bank_i`. A control-store cycle is never extended.
- R9: `mode_i` encodes 00 no memory, 01 page-zero ([d] or [X]), 10 Y-indexed ([Y,d] or [Y,X]), 11 Y-indexed post-increment. On an extended 01 access, `sram_addr_mid_o` is 0. In every other case it equals `addr_mid_i`.
- R10: A load is `sram_oe_ni` low with `sram_we_ni` high, and a store is the reverse. Loads in modes 01 and 10 are extended. A mode-11 load is extended only when `to_out_i` is 1. Stores in modes 01–11 are extended unless `to_out_i` is 1. Mode 00 is never extended.
- R11: An active-low asynchronous reset `rst_ni` clears `z_o` and `prefix_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock, one instruction per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sram_oe_ni | input | 1 | SRAM output enable from the CPU, active low |
| sram_we_ni | input | 1 | SRAM write enable from the CPU, active low |
| code_i | input | 8 | Low address byte (control code in a control store) |
| addr_mid_i | input | 8 | Upper CPU address byte (Y in Y-addressed forms) |
| alu_i | input | 8 | ALU output lines (accumulator in a control store) |
| mode_i | input | 2 | Addressing mode of the current instruction |
| to_out_i | input | 1 | Current instruction targets the output register |
| bank_i | input | 3 | Upper address from the existing bank logic |
| vbank_even_i | input | 3 | Upper bits of the even-pixel video bank |
| vbank_odd_i | input | 3 | Upper bits of the odd-pixel video bank |
| sram_addr_hi_o | output | 3 | SRAM address bits 18:16 |
| sram_addr_mid_o | output | 8 | SRAM address bits 15:8 |
| ctrl_strobe_o | output | 1 | Ordinary control code for the bank logic |
| z_o | output | 3 | High-address register |
| prefix_o | output | 1 | Prefix armed for the current instruction |

## Verification
The hardest case is the prefix meeting an access that the rules refuse to widen. A store to the output register and a post-increment load that does not target it both show the bank value, just as an unprefixed access does. The stimulus therefore re-arms the prefix with a code that leaves `z` unchanged before every such access, so `z` and `bank_i` always differ when compared. Ordered sequences also chain two arming stores back to back, and follow an arm with a non-memory cycle, to show when the flag is consumed.

// File: rtl/far_ext_pkg.sv
package far_ext_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_ZP   = 2'b01,
    MODE_YIDX = 2'b10,
    MODE_YINC = 2'b11
  } mem_mode_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_IMM  = 3'd1,
    SRC_AC   = 3'd2,
    SRC_Y    = 3'd3,
    SRC_VID  = 3'd4
  } z_src_e;

  typedef struct packed {
    z_src_e src;
    logic   arm;
  } z_op_t;
endpackage

// File: rtl/far_ext_decode.sv
module far_ext_decode
  import far_ext_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [BYTE_W-1:0] code_i,
  output logic              ctrl_cyc_o,
  output logic              ordinary_o,
  output z_op_t             op_o
);
  localparam logic [3:0] NIB_REG   = 4'h1;
  localparam logic [3:0] NIB_IMM   = 4'h2;
  localparam logic [3:0] NIB_IMM_P = 4'h3;

  logic [3:0] nib_lo;
  logic [2:0] sel;
  logic       pfx_bit;

  assign nib_lo     = code_i[3:0];
  assign sel        = code_i[6:4];
  assign pfx_bit    = code_i[BYTE_W-1];
  assign ctrl_cyc_o = !oe_ni && !we_ni;
  assign ordinary_o = ctrl_cyc_o && (code_i[1:0] == 2'b00);

  always_comb begin
    op_o = '{src: SRC_NONE, arm: 1'b0};
    if (ctrl_cyc_o) begin
      unique case (nib_lo)
        NIB_REG: begin
          unique case (sel)
            3'd4:    op_o = '{src: SRC_NONE, arm: pfx_bit};
            3'd5:    op_o = '{src: SRC_AC,   arm: pfx_bit};
            3'd6:    op_o = '{src: SRC_Y,    arm: pfx_bit};
            3'd7:    op_o = '{src: SRC_VID,  arm: pfx_bit};
            default: op_o = '{src: SRC_NONE, arm: 1'b0};
          endcase
        end
        NIB_IMM:   op_o = '{src: SRC_IMM, arm: 1'b0};
        NIB_IMM_P: op_o = '{src: SRC_IMM, arm: 1'b1};
        default:   op_o = '{src: SRC_NONE, arm: 1'b0};
      endcase
    end
  end
endmodule

// File: rtl/far_ext_zreg.sv
module far_ext_zreg
  import far_ext_pkg::*;
#(
  parameter int Z_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  z_op_t          op_i,
  input  logic [Z_W-1:0] imm_i,
  input  logic [Z_W-1:0] ac_i,
  input  logic           ac_msb_i,
  input  logic [Z_W-1:0] y_i,
  input  logic [Z_W-1:0] vid_even_i,
  input  logic [Z_W-1:0] vid_odd_i,
  output logic [Z_W-1:0] z_o,
  output logic           prefix_o
);
  logic [Z_W-1:0] z_q, z_d;
  logic           pfx_q;

  always_comb begin
    z_d = z_q;
    unique case (op_i.src)
      SRC_IMM: z_d = imm_i;
      SRC_AC:  z_d = ac_i;
      SRC_Y:   z_d = y_i;
      SRC_VID: z_d = ac_msb_i ? vid_odd_i : vid_even_i;
      default: z_d = z_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q   <= '0;
      pfx_q <= 1'b0;
    end else begin
      z_q   <= z_d;
      pfx_q <= op_i.arm; // one-shot: any other instruction drops it
    end
  end

  assign z_o      = z_q;
  assign prefix_o = pfx_q;
endmodule

// File: rtl/far_ext_mux.sv
module far_ext_mux
  import far_ext_pkg::*;
#(
  parameter int Z_W    = 3,
  parameter int BYTE_W = 8
) (
  input  logic              prefix_i,
  input  logic [Z_W-1:0]    z_i,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  mem_mode_e         mode_i,
  input  logic              to_out_i,
  input  logic [Z_W-1:0]    bank_i,
  input  logic [BYTE_W-1:0] mid_i,
  output logic [Z_W-1:0]    hi_o,
  output logic [BYTE_W-1:0] mid_o
);
  logic is_ld, is_st, ld_ok, st_ok, ext;

  assign is_ld = !oe_ni && we_ni;
  assign is_st = oe_ni && !we_ni;

  always_comb begin
    ld_ok = 1'b0;
    st_ok = 1'b0;
    unique case (mode_i)
      MODE_ZP, MODE_YIDX: begin ld_ok = 1'b1;     st_ok = !to_out_i; end
      MODE_YINC:          begin ld_ok = to_out_i; st_ok = !to_out_i; end
      default:            begin ld_ok = 1'b0;     st_ok = 1'b0;      end
    endcase
  end

  assign ext   = prefix_i && ((is_ld && ld_ok) || (is_st && st_ok));
  assign hi_o  = ext ? z_i : bank_i;
  assign mid_o = (ext && mode_i == MODE_ZP) ? '0 : mid_i;
endmodule

// File: rtl/far_ext_unit.sv
module far_ext_unit
  import far_ext_pkg::*;
#(
  parameter int Z_W    = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sram_oe_ni,
  input  logic              sram_we_ni,
  input  logic [BYTE_W-1:0] code_i,
  input  logic [BYTE_W-1:0] addr_mid_i,
  input  logic [BYTE_W-1:0] alu_i,
  input  logic [1:0]        mode_i,
  input  logic              to_out_i,
  input  logic [Z_W-1:0]    bank_i,
  input  logic [Z_W-1:0]    vbank_even_i,
  input  logic [Z_W-1:0]    vbank_odd_i,
  output logic [Z_W-1:0]    sram_addr_hi_o,
  output logic [BYTE_W-1:0] sram_addr_mid_o,
  output logic              ctrl_strobe_o,
  output logic [Z_W-1:0]    z_o,
  output logic              prefix_o
);
  z_op_t          op;
  logic           ctrl_cyc;
  logic [Z_W-1:0] z;
  logic           pfx;
  logic           unused_alu;

  assign unused_alu = ^{alu_i[BYTE_W-2:Z_W], ctrl_cyc};

  far_ext_decode #(.BYTE_W(BYTE_W)) i_decode (
    .oe_ni      (sram_oe_ni),
    .we_ni      (sram_we_ni),
    .code_i     (code_i),
    .ctrl_cyc_o (ctrl_cyc),
    .ordinary_o (ctrl_strobe_o),
    .op_o       (op)
  );

  far_ext_zreg #(.Z_W(Z_W)) i_zreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .imm_i      (code_i[4 +: Z_W]),
    .ac_i       (alu_i[Z_W-1:0]),
    .ac_msb_i   (alu_i[BYTE_W-1]),
    .y_i        (addr_mid_i[Z_W-1:0]),
    .vid_even_i (vbank_even_i),
    .vid_odd_i  (vbank_odd_i),
    .z_o        (z),
    .prefix_o   (pfx)
  );

  far_ext_mux #(.Z_W(Z_W), .BYTE_W(BYTE_W)) i_mux (
    .prefix_i (pfx),
    .z_i      (z),
    .oe_ni    (sram_oe_ni),
    .we_ni    (sram_we_ni),
    .mode_i   (mem_mode_e'(mode_i)),
    .to_out_i (to_out_i),
    .bank_i   (bank_i),
    .mid_i    (addr_mid_i),
    .hi_o     (sram_addr_hi_o),
    .mid_o    (sram_addr_mid_o)
  );

  assign z_o      = z;
  assign prefix_o = pfx;
endmodule

// File: rtl/far_ext_unit_chk.sv
module far_ext_unit_chk #(
  parameter int Z_W    = 3,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sram_oe_ni,
  input logic              sram_we_ni,
  input logic [BYTE_W-1:0] code_i,
  input logic [BYTE_W-1:0] addr_mid_i,
  input logic [BYTE_W-1:0] alu_i,
  input logic [1:0]        mode_i,
  input logic              to_out_i,
  input logic [Z_W-1:0]    bank_i,
  input logic [Z_W-1:0]    vbank_even_i,
  input logic [Z_W-1:0]    vbank_odd_i,
  input logic [Z_W-1:0]    sram_addr_hi_o,
  input logic [BYTE_W-1:0] sram_addr_mid_o,
  input logic              ctrl_strobe_o,
  input logic [Z_W-1:0]    z_o,
  input logic              prefix_o
);
  logic ctrl_cyc;
  assign ctrl_cyc = !sram_oe_ni && !sram_we_ni;

  assert_strobe_ctrl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_strobe_o |-> (ctrl_cyc && code_i[1:0] == 2'b00));

  assert_z_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_cyc |=> $stable(z_o));

  assert_prefix_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefix_o && !ctrl_cyc) |=> !prefix_o);

  assert_bank_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prefix_o || ctrl_cyc) |-> (sram_addr_hi_o == bank_i));

  assert_mid_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefix_o && !sram_oe_ni && sram_we_ni && mode_i == 2'b01) |-> (sram_addr_mid_o == '0));

  assert_out_store_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_oe_ni && !sram_we_ni && to_out_i) |-> (sram_addr_hi_o == bank_i));

  assert_reset_clear_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (z_o == '0 && !prefix_o));
endmodule

bind far_ext_unit far_ext_unit_chk #(.Z_W(Z_W), .BYTE_W(BYTE_W)) i_far_ext_unit_chk (.*);

// File: tb/test_far_ext_unit.sv
module test_far_ext_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       sram_oe_ni, sram_we_ni, to_out_i;
  logic [7:0] code_i, addr_mid_i, alu_i, sram_addr_mid_o;
  logic [1:0] mode_i;
  logic [2:0] bank_i, vbank_even_i, vbank_odd_i, sram_addr_hi_o, z_o;
  logic       ctrl_strobe_o, prefix_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = !clk_i;

  far_ext_unit i_far_ext_unit (.*);

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] mid;
    logic [7:0] alu;
    logic       strobe;
    logic [2:0] z;
    logic       pfx;
  } vec_t;

  // even bank 5, odd bank 2, z chained from reset value 0
  localparam vec_t VEC [16] = '{
    '{8'h41, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0},  // R6 no-op
    '{8'h52, 8'h00, 8'h00, 1'b0, 3'd5, 1'b0},  // R2 immediate
    '{8'hB3, 8'h00, 8'h00, 1'b0, 3'd3, 1'b1},  // R2 immediate + arm
    '{8'h51, 8'h00, 8'h06, 1'b0, 3'd6, 1'b0},  // R3 accumulator
    '{8'hD1, 8'h00, 8'h0D, 1'b0, 3'd5, 1'b1},  // R3 accumulator + arm
    '{8'h61, 8'h04, 8'h00, 1'b0, 3'd4, 1'b0},  // R4 Y
    '{8'hE1, 8'h0B, 8'h00, 1'b0, 3'd3, 1'b1},  // R4 Y + arm
    '{8'h71, 8'h00, 8'h80, 1'b0, 3'd2, 1'b0},  // R5 odd bank
    '{8'hF1, 8'h00, 8'h00, 1'b0, 3'd5, 1'b1},  // R5 even bank + arm
    '{8'hC1, 8'h00, 8'h00, 1'b0, 3'd5, 1'b1},  // R6 arm only
    '{8'h31, 8'h00, 8'h07, 1'b0, 3'd5, 1'b0},  // R6 unassigned
    '{8'h40, 8'h00, 8'h00, 1'b1, 3'd5, 1'b0},  // R1 ordinary code
    '{8'h05, 8'h00, 8'h00, 1'b0, 3'd5, 1'b0},  // R1 R6 neither
    '{8'hA1, 8'h00, 8'h03, 1'b0, 3'd5, 1'b0},  // R6 unassigned with bit 7
    '{8'h72, 8'h00, 8'h00, 1'b0, 3'd7, 1'b0},  // R2
    '{8'h12, 8'h00, 8'h00, 1'b0, 3'd1, 1'b0}   // R2
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one instruction at a falling edge, let it settle
  task automatic drive(input logic oe, input logic we, input logic [7:0] code,
                       input logic [7:0] mid, input logic [7:0] alu,
                       input logic [1:0] mode, input logic out);
    sram_oe_ni = oe; sram_we_ni = we; code_i = code; addr_mid_i = mid;
    alu_i = alu; mode_i = mode; to_out_i = out;
    #1;
  endtask

  task automatic ctrl(input logic [7:0] code);
    drive(1'b0, 1'b0, code, 8'h00, 8'h00, 2'b00, 1'b0);
    @(negedge clk_i);
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 2'b00, 1'b0);
    @(negedge clk_i);
  endtask

  initial begin
    #100us;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    bank_i = 3'd6; vbank_even_i = 3'd5; vbank_odd_i = 3'd2;
    drive(1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 2'b00, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R11 reset z", z_o, 0);
    check("R11 reset prefix", prefix_o, 0);
    check("R8 reset hi", sram_addr_hi_o, 6);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VEC[i]) begin
      drive(1'b0, 1'b0, VEC[i].code, VEC[i].mid, VEC[i].alu, 2'b00, 1'b0);
      check("R1 strobe", ctrl_strobe_o, VEC[i].strobe);
      check("R8 ctrl cycle hi", sram_addr_hi_o, 6);
      @(negedge clk_i);
      check("R2-R6 z", z_o, VEC[i].z);
      check("R7 prefix armed", prefix_o, VEC[i].pfx);
      idle();
    end

    // R8 R9 extended page-zero load
    ctrl(8'h53);
    drive(1'b0, 1'b1, 8'h10, 8'h77, 8'h00, 2'b01, 1'b0);
    check("R8 zp load hi", sram_addr_hi_o, 5);
    check("R9 zp load mid", sram_addr_mid_o, 0);
    @(negedge clk_i);
    check("R7 prefix consumed", prefix_o, 0);
    drive(1'b0, 1'b1, 8'h10, 8'h77, 8'h00, 2'b01, 1'b0);
    check("R8 unprefixed hi", sram_addr_hi_o, 6);
    check("R9 unprefixed mid", sram_addr_mid_o, 8'h77);
    @(negedge clk_i);

    // R9 Y-indexed keeps middle byte
    ctrl(8'hC1);
    drive(1'b0, 1'b1, 8'h10, 8'h33, 8'h00, 2'b10, 1'b0);
    check("R8 yidx hi", sram_addr_hi_o, 5);
    check("R9 yidx mid", sram_addr_mid_o, 8'h33);
    @(negedge clk_i);

    // R10 destination and direction rules
    ctrl(8'hC1);
    drive(1'b1, 1'b0, 8'h10, 8'h00, 8'h00, 2'b01, 1'b1);
    check("R10 out store", sram_addr_hi_o, 6);
    @(negedge clk_i);
    ctrl(8'hC1);
    drive(1'b0, 1'b1, 8'h10, 8'h12, 8'h00, 2'b11, 1'b0);
    check("R10 yinc load to ac", sram_addr_hi_o, 6);
    @(negedge clk_i);
    ctrl(8'hC1);
    drive(1'b0, 1'b1, 8'h10, 8'h12, 8'h00, 2'b11, 1'b1);
    check("R10 yinc load to out", sram_addr_hi_o, 5);
    check("R9 yinc mid", sram_addr_mid_o, 8'h12);
    @(negedge clk_i);
    ctrl(8'hC1);
    drive(1'b1, 1'b0, 8'h10, 8'h12, 8'h00, 2'b11, 1'b0);
    check("R10 yinc store", sram_addr_hi_o, 5);
    @(negedge clk_i);

    // R7 non-memory instruction consumes prefix
    ctrl(8'hC1);
    idle();
    drive(1'b0, 1'b1, 8'h10, 8'h00, 8'h00, 2'b01, 1'b0);
    check("R7 consumed by idle", sram_addr_hi_o, 6);
    @(negedge clk_i);

    // R7 back-to-back arming keeps prefix, second Z wins
    ctrl(8'h23);
    ctrl(8'h73);
    check("R7 rearm", prefix_o, 1);
    drive(1'b1, 1'b0, 8'h10, 8'h40, 8'h00, 2'b01, 1'b0);
    check("R8 rearm store hi", sram_addr_hi_o, 7);
    check("R9 zp store mid", sram_addr_mid_o, 0);
    @(negedge clk_i);

    // R11 asynchronous reset mid-run
    ctrl(8'h53);
    rst_ni = 1'b0;
    #1;
    check("R11 async z", z_o, 0);
    check("R11 async prefix", prefix_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule